// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It runs a nine-instruction load/store subset. The subset has four arithmetic and logic operations, a signed set-on-less-than, word load, word store, a compare-equal branch and an absolute jump. A single datapath serves every instruction class. It contains the program counter, a register file with 32 entries, two read ports and one write port, an ALU, a sign extender, next-PC selection, and a decoder that turns the opcode and function fields into a control bundle.

Instruction memory and data memory are word arrays held inside the core. A bench fills them before it releases reset. To follow the core from outside, the bench watches three things at the ports: the current program counter, the register write-back bus, and the data-memory write bus. All three describe the instruction that is executing in the current cycle.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. The first cycle after reset is released executes the word at address 0.
- R2: When an instruction neither branches nor jumps, the next program counter is the current value plus 4.
- R3: Opcode 6'h00 selects a register-register operation, with sources in bits [25:21] and [20:16] and the destination in bits [15:11]. Function code 6'h20 adds, 6'h22 subtracts (first source minus second), 6'h24 takes the bitwise AND and 6'h25 takes the bitwise OR. The result is written to the destination.
- R4: Function code 6'h2A compares the two sources as signed numbers. It writes 1 when the first is less than the second, and 0 otherwise.
- R5: Opcode 6'h23 loads the data word at the address formed by adding the base register (bits [25:21]) and the sign-extended 16-bit offset (bits [15:0]). The word is written into the register named by bits [20:16].
- R6: Opcode 6'h2B stores the register named by bits [20:16] at the address formed by adding the base register and the sign-extended offset. It does not write any register.
- R7: Opcode 6'h04 compares the registers in bits [25:21] and [20:16]. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4. Negative offsets are supported.
- R8: Opcode 6'h02 sets the next PC to the upper four bits of PC+4, followed by instruction bits [25:0], followed by two zero bits.
- R9: Register 0 always reads as zero. A write aimed at register 0 has no effect.
- R10: The register file is written only by instructions that assert the write enable, and at most one register is loaded on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Program counter of the instruction executing now |
| wb_en_o | output | 1 | Register write enable of the current instruction |
| wb_idx_o | output | 5 | Register write index |
| wb_data_o | output | 32 | Register write data |
| st_en_o | output | 1 | Data-memory write enable |
| st_addr_o | output | 32 | Data-memory byte address (the ALU result) |
| st_data_o | output | 32 | Data-memory write data |

## Verification
Three behaviours are hard to observe from the ports. A write to register 0 must be shown to have no effect, a taken branch must be shown to skip instructions, and a branch with a negative offset must resolve correctly. The program covers all three. It first writes a non-zero sum to register 0 and then stores register 0, so a zero must appear on the store bus. It then stores a word through a negative offset and loads the word back, and the equality of those two values decides whether a forward branch is taken over two poisoned instructions. The program ends in a branch whose offset is -1, which keeps the PC at a fixed address. A reference model inside the bench predicts every cycle of this program.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    src_imm;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_we: 1'b0,
                 mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_we     = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int IDXW = RIDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] ra,
    input  logic [IDXW-1:0] rb,
    output logic [W-1:0]    rdata_a,
    output logic [W-1:0]    rdata_b,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [W-1:0]    wdata
);
    localparam int NREG = 1 << IDXW;

    logic [W-1:0]    regs [1:NREG-1];
    logic [NREG-1:0] load_en;

    assign load_en[0] = 1'b0;
    for (genvar g = 1; g < NREG; g++) begin : g_load
        assign load_en[g] = we && (waddr == IDXW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 1; i < NREG; i++) begin
            if (load_en[i]) regs[i] <= wdata;
        end
    end

    assign rdata_a = (ra == '0) ? '0 : regs[ra];
    assign rdata_b = (rb == '0) ? '0 : regs[rb];

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst) $onehot0(load_en)); // R10
    AST_NO_WE_NO_LOAD: assert property (@(posedge clk) disable iff (rst) !we |-> (load_en == '0)); // R10
    AST_R0_READ: assert property (@(posedge clk) disable iff (rst) (ra == '0) |-> (rdata_a == '0)); // R9
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        wb_en_o,
    output logic [4:0]  wb_idx_o,
    output logic [31:0] wb_data_o,
    output logic        st_en_o,
    output logic [31:0] st_addr_o,
    output logic [31:0] st_data_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
    logic [XLEN-1:0] instr, imm, rdata_a, rdata_b, alu_b, alu_y, ld_word, wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic alu_zero;
    ctrl_t ctrl;

    assign instr = imem[pc_q[IAW+1:2]];
    assign imm   = sext16(instr[15:0]);

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wb_idx = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    sc_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra      (instr[25:21]),
        .rb      (instr[20:16]),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b),
        .we      (ctrl.reg_we),
        .waddr   (wb_idx),
        .wdata   (wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm : rdata_b;

    sc_alu u_alu (
        .op   (ctrl.alu_op),
        .a    (rdata_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign ld_word = dmem[alu_y[DAW+1:2]];
    assign wb_data = ctrl.mem_to_reg ? ld_word : alu_y;

    always_ff @(posedge clk) begin
        if (ctrl.mem_we) dmem[alu_y[DAW+1:2]] <= rdata_b;
    end

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump)                      pc_next = j_tgt;
        else if (ctrl.branch && alu_zero)   pc_next = br_tgt;
        else                                pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign wb_en_o   = ctrl.reg_we;
    assign wb_idx_o  = wb_idx;
    assign wb_data_o = wb_data;
    assign st_en_o   = ctrl.mem_we;
    assign st_addr_o = alu_y;
    assign st_data_o = rdata_b;

    AST_RST_PC: assert property (@(posedge clk) rst |=> (pc_q == '0)); // R1
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_BEQ_NT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && (rdata_a != rdata_b)) |=> (pc_q == $past(pc_q) + 32'd4)); // R7
    AST_JMP_TGT: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00})); // R8
    AST_ST_NO_WB: assert property (@(posedge clk) disable iff (rst)
        st_en_o |-> !wb_en_o); // R6
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
    logic wb_en_o, st_en_o;
    logic [4:0] wb_idx_o;

    always #5 clk = ~clk;

    sc_core u0 (.clk(clk), .rst(rst), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
                .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o));

    typedef struct {
        logic [31:0] pc;
        logic        wb;
        logic [4:0]  widx;
        logic [31:0] wdat;
        logic        st;
        logic [31:0] saddr;
        logic [31:0] sdat;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] prog [64];
    logic [31:0] mref [64];
    logic [31:0] rref [32];

    function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int off);
        return {op, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // driver: reference model pushes one expected item per executed instruction
    task automatic drive_expect(int steps);
        logic [31:0] pc = 0;
        for (int s = 0; s < steps; s++) begin
            item_t it;
            logic [31:0] ins = prog[pc[7:2]];
            logic [5:0] op = ins[31:26];
            int rs = int'(ins[25:21]);
            int rt = int'(ins[20:16]);
            int rd = int'(ins[15:11]);
            logic [31:0] a = rref[rs];
            logic [31:0] b = rref[rt];
            logic [31:0] off = {{16{ins[15]}}, ins[15:0]};
            logic [31:0] npc = pc + 4;
            it.pc = pc; it.wb = 0; it.widx = 0; it.wdat = 0;
            it.st = 0; it.saddr = 0; it.sdat = 0; it.tag = "R2";
            case (op)
                6'h00: begin
                    it.wb = 1; it.widx = 5'(rd); it.tag = "R3";
                    case (ins[5:0])
                        6'h20: it.wdat = a + b;
                        6'h22: it.wdat = a - b;
                        6'h24: it.wdat = a & b;
                        6'h25: it.wdat = a | b;
                        default: begin it.wdat = ($signed(a) < $signed(b)) ? 1 : 0; it.tag = "R4"; end
                    endcase
                    if (rd == 0) it.tag = "R9";
                end
                6'h23: begin
                    it.wb = 1; it.widx = 5'(rt); it.wdat = mref[5'((a + off) >> 2)]; it.tag = "R5";
                end
                6'h2B: begin
                    it.st = 1; it.saddr = a + off; it.sdat = b;
                    mref[5'((a + off) >> 2)] = b;
                    it.tag = (rt == 0) ? "R9" : "R6";
                end
                6'h04: begin
                    it.tag = "R7";
                    if (a == b) npc = pc + 4 + (off << 2);
                end
                default: begin
                    it.tag = "R8";
                    npc = {npc[31:28], ins[25:0], 2'b00};
                end
            endcase
            if (it.wb && it.widx != 0) rref[it.widx] = it.wdat;
            exp_q.push_back(it);
            pc = npc;
        end
    endtask

    // monitor: pops expected items and compares away from the clock edge
    task automatic monitor();
        while (exp_q.size() > 0) begin
            item_t it = exp_q.pop_front();
            #1;
            check(it.tag, "pc", pc_o, it.pc);
            check(it.wb ? it.tag : "R10", "wb_en", 32'(wb_en_o), 32'(it.wb));
            if (it.wb) begin
                check(it.tag, "wb_idx", 32'(wb_idx_o), 32'(it.widx));
                check(it.tag, "wb_data", wb_data_o, it.wdat);
            end
            check(it.st ? it.tag : "R6", "st_en", 32'(st_en_o), 32'(it.st));
            if (it.st) begin
                check(it.tag, "st_addr", st_addr_o, it.saddr);
                check(it.tag, "st_data", st_data_o, it.sdat);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin prog[i] = enc_r(6'h20, 0, 0, 0); mref[i] = 0; end
        for (int i = 0; i < 32; i++) rref[i] = 0;
        mref[0] = 32'd7; mref[1] = 32'hFFFF_FFFD;
        prog[0]  = enc_i(6'h23, 0, 1, 0);      // r1 = 7
        prog[1]  = enc_i(6'h23, 0, 2, 4);      // r2 = -3
        prog[2]  = enc_r(6'h20, 3, 1, 2);      // R3 add
        prog[3]  = enc_r(6'h22, 4, 1, 2);      // R3 sub
        prog[4]  = enc_r(6'h24, 5, 1, 2);      // R3 and
        prog[5]  = enc_r(6'h25, 6, 1, 2);      // R3 or
        prog[6]  = enc_r(6'h2A, 7, 2, 1);      // R4 -3 < 7
        prog[7]  = enc_r(6'h2A, 8, 1, 2);      // R4 7 < -3 false
        prog[8]  = enc_r(6'h20, 0, 1, 1);      // R9 write r0
        prog[9]  = enc_i(6'h2B, 0, 0, 8);      // R9 store r0
        prog[10] = enc_r(6'h20, 9, 4, 4);      // r9 = 20
        prog[11] = enc_i(6'h2B, 9, 3, -8);     // R6 negative offset
        prog[12] = enc_i(6'h23, 0, 11, 12);    // R5 load back
        prog[13] = enc_i(6'h04, 3, 11, 2);     // R7 taken forward
        prog[14] = enc_r(6'h20, 12, 1, 1);
        prog[15] = enc_r(6'h20, 12, 1, 1);
        prog[16] = enc_i(6'h04, 1, 2, 5);      // R7 not taken
        prog[17] = {6'h02, 26'd20};            // R8 jump
        prog[18] = enc_r(6'h20, 13, 1, 1);
        prog[19] = enc_r(6'h20, 13, 1, 1);
        prog[20] = enc_i(6'h04, 0, 0, -1);     // R7 self loop
        for (int i = 0; i < 64; i++) u0.imem[i] = prog[i];
        u0.dmem[0] = 32'd7; u0.dmem[1] = 32'hFFFF_FFFD;

        drive_expect(30);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'd0);
        rst = 1'b0;
        monitor();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule